// File: doc/BRIEF.md
# Prescaled Single-Channel Pulse-Width Modulator

This block makes one pulse-width modulated output whose timing a host sets through four 16-bit registers on a simple synchronous bus. The bus has a byte address, a write strobe, write data and combinational read data. A power-of-two prescaler turns the system clock into a tick enable. A 10-bit counter advances on each tick and compares against a programmable period and duty, both counted in ticks.

A polarity bit picks which level is the resting level and which is the driven level. While the channel is off, the output sits at the resting level. The period may only be changed while the channel is off. The duty may be changed at any time: a new value is held in a shadow register and moves into the live compare value when the counter wraps, so a running cycle is never cut short.

When the channel is switched on, the counter and the prescaler start again from zero. The first cycle therefore begins at a known point. The host converts a wanted period and duty into tick counts and picks the shift that gives the resolution it needs.

Top module: `pwm_shiftdiv`

## Requirements
- R1: Registers sit at byte addresses 0 (control: bit 0 run, bit 1 polarity), 2 (period, bits 9:0), 4 (duty, bits 9:0) and 6 (shift, bits 4:0). Each register reads back its stored value. Unused bits and any other address read as zero.
- R2: While run is 0, the output is held at the resting level: high when polarity is 0, low when polarity is 1.
- R3: While running, the output is low during the driven part of a cycle when polarity is 0, and high during it when polarity is 1.
- R4: While running, the counter steps from 0 to period−1 and then wraps, so each cycle lasts period ticks. The driven level is shown while count < duty.
- R5: A tick occurs once every 2^shift system clocks, so each count value lasts 2^shift clocks.
- R6: A stored shift above 11 divides as if it were 11. The register still reads back the value written.
- R7: A write to the period register while run is 1 is ignored, and the old period stays in force.
- R8: A duty written while running takes effect only at the next counter wrap. While the channel is off, the written duty is used from the first cycle.
- R9: A duty of 0 gives a constant resting level. A duty equal to or greater than the period gives a constant driven level.
- R10: The write that sets run starts the counter and prescaler from zero, so count 0 is shown in the very next clock cycle.
- R11: After reset, every register reads zero and the output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
A wrong count or prescaler value moves the driven-to-resting edge. The error therefore appears at pwm_out within one tick, which is 2^shift clocks, and at the latest at the next wrap. A corrupted live duty value changes the pulse width in the very cycle it is used. A shadow value taken too early shows as a cycle that is cut short before the wrap. A period that changes while running shows up in the read data at once, and in the cycle length within one period. The bench follows the output clock by clock against a model of the counting rules, so any of these errors shows up within one output cycle.

// File: rtl/pwm_shiftdiv_pkg.sv
package pwm_shiftdiv_pkg;
   // byte addresses of the four registers
   localparam logic [2:0] ADR_CTRL   = 3'd0;
   localparam logic [2:0] ADR_PERIOD = 3'd2;
   localparam logic [2:0] ADR_DUTY   = 3'd4;
   localparam logic [2:0] ADR_SHIFT  = 3'd6;

   // control register bit positions
   localparam int unsigned CTRL_RUN_BIT = 0;
   localparam int unsigned CTRL_POL_BIT = 1;

   typedef struct packed {
      logic pol;
      logic run;
   } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_shiftdiv_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned CNT_W   = 10,
   parameter int unsigned SHIFT_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         addr,
   input  logic               wr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   output ctrl_t              ctrl,
   output logic [CNT_W-1:0]   period,
   output logic [CNT_W-1:0]   duty_shadow,
   output logic [SHIFT_W-1:0] shift
);
   localparam int unsigned PAD_CNT   = DATA_W - CNT_W;
   localparam int unsigned PAD_SHIFT = DATA_W - SHIFT_W;
   localparam int unsigned PAD_CTRL  = DATA_W - 2;

   logic sel_ctrl, sel_period, sel_duty, sel_shift;
   logic unused_wdata_hi;

   assign sel_ctrl   = wr && (addr == ADR_CTRL);
   assign sel_period = wr && (addr == ADR_PERIOD);
   assign sel_duty   = wr && (addr == ADR_DUTY);
   assign sel_shift  = wr && (addr == ADR_SHIFT);
   assign unused_wdata_hi = ^wdata[DATA_W-1:CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl        <= '0;
         period      <= '0;
         duty_shadow <= '0;
         shift       <= '0;
      end else begin
         if (sel_ctrl) begin
            ctrl.run <= wdata[CTRL_RUN_BIT];
            ctrl.pol <= wdata[CTRL_POL_BIT];
         end
         // period is locked while the channel runs
         if (sel_period && !ctrl.run)
            period <= wdata[CNT_W-1:0];
         if (sel_duty)
            duty_shadow <= wdata[CNT_W-1:0];
         if (sel_shift)
            shift <= wdata[SHIFT_W-1:0];
      end
   end

   always_comb begin
      case (addr)
         ADR_CTRL:   rdata = {{PAD_CTRL{1'b0}}, ctrl.pol, ctrl.run};
         ADR_PERIOD: rdata = {{PAD_CNT{1'b0}}, period};
         ADR_DUTY:   rdata = {{PAD_CNT{1'b0}}, duty_shadow};
         ADR_SHIFT:  rdata = {{PAD_SHIFT{1'b0}}, shift};
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int unsigned SHIFT_W   = 5,
   parameter int unsigned MAX_SHIFT = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);
   generate
      if (MAX_SHIFT == 0) begin : g_nodiv
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ (^shift);
         assign tick = run;
      end else begin : g_div
         localparam int unsigned DIV_W = MAX_SHIFT;
         localparam logic [SHIFT_W-1:0] SHIFT_CAP = SHIFT_W'(MAX_SHIFT);

         logic [SHIFT_W-1:0] shift_eff;
         logic [DIV_W-1:0]   mask;
         logic [DIV_W-1:0]   div_q;

         assign shift_eff = (shift > SHIFT_CAP) ? SHIFT_CAP : shift;

         for (genvar i = 0; i < DIV_W; i++) begin : g_mask
            assign mask[i] = (32'(shift_eff) > i);
         end

         assign tick = run && ((div_q & mask) == mask);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (!run || tick)
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             pol,
   input  logic             tick,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] duty_next,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] duty_live,
   output logic             pwm_out
);
   logic [CNT_W:0] count_inc;
   logic           at_wrap;
   logic           driven;

   assign count_inc = {1'b0, count} + 1'b1;
   assign at_wrap   = count_inc >= {1'b0, period};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count     <= '0;
         duty_live <= '0;
      end else if (!run) begin
         count     <= '0;
         duty_live <= duty_next;
      end else if (tick) begin
         if (at_wrap) begin
            count     <= '0;
            duty_live <= duty_next;
         end else begin
            count <= count_inc[CNT_W-1:0];
         end
      end
   end

   assign driven  = run && (count < duty_live);
   assign pwm_out = driven ? pol : !pol;
endmodule

// File: rtl/pwm_shiftdiv.sv
module pwm_shiftdiv
   import pwm_shiftdiv_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CNT_W     = 10,
   parameter int unsigned SHIFT_W   = 5,
   parameter int unsigned MAX_SHIFT = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwm_out
);
   generate
      if (CNT_W >= DATA_W) begin : g_bad_cnt
         $error("CNT_W must be narrower than DATA_W");
      end
      if (SHIFT_W >= DATA_W) begin : g_bad_shift
         $error("SHIFT_W must be narrower than DATA_W");
      end
      if (MAX_SHIFT >= (1 << SHIFT_W)) begin : g_bad_max
         $error("MAX_SHIFT must fit in SHIFT_W bits");
      end
   endgenerate

   ctrl_t              ctrl;
   logic [CNT_W-1:0]   period_q;
   logic [CNT_W-1:0]   duty_shadow;
   logic [SHIFT_W-1:0] shift_q;
   logic               tick;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   duty_live;

   pwm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (bus_addr),
      .wr         (bus_wr),
      .wdata      (bus_wdata),
      .rdata      (bus_rdata),
      .ctrl       (ctrl),
      .period     (period_q),
      .duty_shadow(duty_shadow),
      .shift      (shift_q)
   );

   pwm_prescaler #(.SHIFT_W(SHIFT_W), .MAX_SHIFT(MAX_SHIFT)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ctrl.run),
      .shift(shift_q),
      .tick (tick)
   );

   pwm_wavegen #(.CNT_W(CNT_W)) u_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl.run),
      .pol      (ctrl.pol),
      .tick     (tick),
      .period   (period_q),
      .duty_next(duty_shadow),
      .count    (cnt_q),
      .duty_live(duty_live),
      .pwm_out  (pwm_out)
   );
endmodule

// File: rtl/pwm_shiftdiv_chk.sv
module pwm_shiftdiv_chk #(
   parameter int unsigned CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             pol,
   input logic             tick,
   input logic [CNT_W-1:0] period,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] duty_live,
   input logic             pwm_out
);
   assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (pwm_out == !pol));

   assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && period != '0) |-> (count < period));

   assert_count_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(tick)) |-> $stable(count));

   assert_period_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(period));

   assert_duty_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(tick)) |-> $stable(duty_live));

   assert_clean_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (count == '0));
endmodule

bind pwm_shiftdiv pwm_shiftdiv_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (ctrl.run),
   .pol      (ctrl.pol),
   .tick     (tick),
   .period   (period_q),
   .count    (cnt_q),
   .duty_live(duty_live),
   .pwm_out  (pwm_out)
);

// File: tb/pwm_shiftdiv_test.sv
`timescale 1ns/1ps
module pwm_shiftdiv_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        pwm_out;

   int checks = 0;
   int failures = 0;
   bit sb_on = 1'b0;
   bit done = 1'b0;
   string cur_req = "R11";

   // model of the counting rules
   int m_en = 0, m_pol = 0, m_per = 0, m_shadow = 0, m_shift = 0;
   int m_sub = 0, m_cnt = 0, m_act = 0;

   bit    exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   pwm_shiftdiv uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_pol = 0; m_per = 0; m_shadow = 0; m_shift = 0;
         m_sub = 0; m_cnt = 0; m_act = 0;
      end else begin
         int eff, mask, old_en;
         bit tk;
         eff = (m_shift > 11) ? 11 : m_shift;
         mask = (1 << eff) - 1;
         tk = (m_en != 0) && ((m_sub & mask) == mask);
         old_en = m_en;
         if (m_en == 0) begin
            m_sub = 0; m_cnt = 0; m_act = m_shadow;
         end else begin
            m_sub = tk ? 0 : m_sub + 1;
            if (tk) begin
               if (m_cnt + 1 >= m_per) begin m_cnt = 0; m_act = m_shadow; end
               else m_cnt = m_cnt + 1;
            end
         end
         if (bus_wr) begin
            case (bus_addr)
               3'd0: begin m_en = bus_wdata[0]; m_pol = bus_wdata[1]; end
               3'd2: if (old_en == 0) m_per = bus_wdata & 16'h03FF;
               3'd4: m_shadow = bus_wdata & 16'h03FF;
               3'd6: m_shift = bus_wdata & 16'h001F;
               default: ;
            endcase
         end
      end
   end

   // driver side of the scoreboard: expected level for this cycle
   always @(negedge clk) begin
      if (sb_on) begin
         bit act;
         act = (m_en != 0) && (m_cnt < m_act);
         exp_q.push_back(act ? m_pol[0] : !m_pol[0]);
         tag_q.push_back(cur_req);
      end
   end

   // monitor side of the scoreboard
   always @(negedge clk) begin
      #1;
      while (exp_q.size() > 0) begin
         bit e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (pwm_out !== e) begin
            failures++;
            $display("FAIL %s pwm_out actual=%0b expected=%0b at %0t", t, pwm_out, e, $time);
         end
      end
   end

   task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic read_check(input logic [2:0] a, input logic [15:0] e, input string req);
      @(negedge clk);
      bus_addr = a;
      #2;
      checks++;
      if (bus_rdata !== e) begin
         failures++;
         $display("FAIL %s read addr=%0d actual=%h expected=%h", req, a, bus_rdata, e);
      end
   endtask

   task automatic out_check(input logic e, input string req);
      @(negedge clk);
      #2;
      checks++;
      if (pwm_out !== e) begin
         failures++;
         $display("FAIL %s pwm_out actual=%0b expected=%0b", req, pwm_out, e);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      sb_on = 1'b1;

      // R11: reset state
      cur_req = "R11";
      read_check(3'd0, 16'h0000, "R11");
      read_check(3'd2, 16'h0000, "R11");
      read_check(3'd4, 16'h0000, "R11");
      read_check(3'd6, 16'h0000, "R11");
      out_check(1'b1, "R11");

      // R1: readback, reserved bits, odd address
      cur_req = "R1";
      bus_write(3'd6, 16'hFFFF); read_check(3'd6, 16'h001F, "R1");
      bus_write(3'd4, 16'hFFFF); read_check(3'd4, 16'h03FF, "R1");
      bus_write(3'd2, 16'hFFFF); read_check(3'd2, 16'h03FF, "R1");
      read_check(3'd1, 16'h0000, "R1");
      read_check(3'd7, 16'h0000, "R1");
      bus_write(3'd0, 16'hFFFC); read_check(3'd0, 16'h0000, "R1");

      // R2: resting level follows polarity while off
      cur_req = "R2";
      bus_write(3'd0, 16'h0002); read_check(3'd0, 16'h0002, "R2");
      idle(10); out_check(1'b0, "R2");
      bus_write(3'd0, 16'h0000);
      idle(5); out_check(1'b1, "R2");

      // R4 and R3: basic waveform, polarity 0
      cur_req = "R4 R3";
      bus_write(3'd6, 16'd0);
      bus_write(3'd2, 16'd10);
      bus_write(3'd4, 16'd3);
      bus_write(3'd0, 16'h0001);
      idle(45);

      // R7: period locked while running
      cur_req = "R7";
      bus_write(3'd2, 16'd5);
      read_check(3'd2, 16'd10, "R7");
      idle(30);

      // R8: duty change waits for the wrap
      cur_req = "R8";
      idle(4);
      bus_write(3'd4, 16'd7);
      idle(30);

      // R9: duty extremes
      cur_req = "R9";
      bus_write(3'd4, 16'd0);  idle(25);
      bus_write(3'd4, 16'd12); idle(25);
      bus_write(3'd4, 16'd10); idle(25);

      // R3: polarity 1 while running
      cur_req = "R3";
      bus_write(3'd4, 16'd4);
      bus_write(3'd0, 16'h0003);
      idle(30);

      // R10: clean restart
      cur_req = "R10";
      bus_write(3'd0, 16'h0000);
      idle(5);
      bus_write(3'd0, 16'h0001);
      idle(30);

      // R5: divide by 4
      cur_req = "R5";
      bus_write(3'd0, 16'h0000);
      bus_write(3'd6, 16'd2);
      bus_write(3'd2, 16'd4);
      bus_write(3'd4, 16'd1);
      bus_write(3'd0, 16'h0001);
      idle(80);

      // R6: shift above 11 acts as 11
      cur_req = "R6";
      bus_write(3'd0, 16'h0000);
      bus_write(3'd6, 16'd15);
      read_check(3'd6, 16'd15, "R6");
      bus_write(3'd2, 16'd2);
      bus_write(3'd4, 16'd1);
      bus_write(3'd0, 16'h0001);
      idle(4300);

      sb_on = 1'b0;
      idle(3);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule